// File: doc/BRIEF.md
# Event ID matching sequencer

The sequencer accepts 36-bit event identifiers from a trigger source and queues them in a small FIFO. It takes them out one at a time as the identifier under test. While an identifier is under test, the block sends a numbered request strobe to a set of readout channels at a programmable interval. It then collects one reply per channel. A reply counts only if it carries both the number of the latest request and the identifier under test. Once every enabled channel has given such a reply, the identifier is retired and the next one is taken from the queue.

Control inputs stand in for the software-visible registers:
- a halt bit, which is set out of reset;
- a force-skip strobe, which works only while halted;
- the re-request interval.

Status outputs show the identifier under test, the newest identifier received, the queue occupancy, the request number and the retry count. Framing on the channel links and bus decoding sit outside this block.

Top module: `evid_match_seq`

## Requirements
- R1: `cur_id` shows the identifier under test, and `newest_id` shows the last identifier presented with `trig_valid`, including one that a full queue drops. Both reset to 0.
- R2: `fifo_count` gives the number of queued identifiers, not counting the one under test. It resets to 0.
- R3: `halted` is 1 after reset. While the halt bit is 1, no `req_valid` pulse appears. Writing bit 0 of `cfg_wdata` with `cfg_halt_we` changes the halt bit.
- R4: A `force_stb` pulse while halted retires the identifier under test unmatched. The next queued identifier becomes current within four cycles.
- R5: A `force_stb` pulse while not halted has no effect on `cur_id` or `fifo_count`.
- R6: Successive requests for one identifier are `G+1` cycles apart, where G is the interval register. G is written from `cfg_wdata` with `cfg_gap_we` and resets to 0x07FF.
- R7: `cur_tag` resets to 0 and increments by one, modulo 16, on every request. Each `req_valid` pulse comes with the new value.
- R8: `retry_count` counts the requests sent for the identifier under test. It clears when a new identifier becomes current, so it reads 1 after that identifier's first request.
- R9: `retry_count` saturates at 0xFFFF.
- R10: An identifier is retired only when every channel with its `chan_en` bit at 1 has replied since the latest request. Each such reply must carry that request's tag and the current identifier. A stale tag, a wrong identifier or a missing enabled channel blocks the advance. Channel c uses `rsp_tag[4c+3:4c]` and `rsp_id[36c+35:36c]`.
- R11: When there is no identifier under test and the queue is empty, no requests are issued.
- R12: The queue holds 8 identifiers. A push to a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_valid | input | 1 | Strobe: new identifier on `trig_id` |
| trig_id | input | 36 | Identifier from the trigger source |
| chan_en | input | 4 | Channels that take part in matching |
| rsp_valid | input | 4 | Per-channel reply strobe |
| rsp_tag | input | 16 | Per-channel reply tag, 4 bits each |
| rsp_id | input | 144 | Per-channel reply identifier, 36 bits each |
| cfg_wdata | input | 16 | Write data for the halt bit (bit 0) and the interval |
| cfg_halt_we | input | 1 | Write strobe for the halt bit |
| cfg_gap_we | input | 1 | Write strobe for the re-request interval |
| force_stb | input | 1 | Skip the identifier under test (only while halted) |
| req_valid | output | 1 | One-cycle request strobe to all channels |
| cur_tag | output | 4 | Tag of the latest request |
| halted | output | 1 | Current halt bit |
| cur_id | output | 36 | Identifier under test |
| newest_id | output | 36 | Most recent identifier received |
| fifo_count | output | 4 | Queued identifiers, not counting the current one |
| retry_count | output | 16 | Requests sent for the current identifier |

## Verification
The properties assume that every input is synchronous to `clk` and that the strobes are plain levels sampled at the edge. The tag and interval checks also assume that an interval write landing in the request cycle takes effect only from the next request onward. The stimulus changes inputs one nanosecond before a rising edge and holds each strobe for exactly one cycle. It keeps the interval at 20 or more whenever a reply has to land between requests. The interval drops to 0 only in the phase that drives the retry count into saturation, where no match is wanted.

// File: rtl/evid_pkg.sv
// Shared definitions for the event ID matching sequencer.
// Assumes nothing beyond IEEE 1800-2017 synthesis subset.
package evid_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_t;
endpackage

// File: rtl/evid_fifo.sv
// Identifier queue: circular buffer with an occupancy counter.
// A push to a full queue is dropped unless a pop happens in the same cycle.
// Assumes pop is only raised while the queue is not empty.
module evid_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, push_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && (!full || pop);
    assign dout    = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)     rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push_ok && !pop)      count <= count + 1'b1;
            else if (pop && !push_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/evid_hit_track.sv
// Per-channel match tracker. A channel's hit bit sets when it replies with
// the current tag and identifier while capture is enabled; clr wins over cap.
// Assumes the reply buses are packed channel 0 in the low bits.
module evid_hit_track #(
    parameter int NCH  = 4,
    parameter int IDW  = 36,
    parameter int TAGW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                cap,
    input  logic [NCH-1:0]      rsp_valid,
    input  logic [NCH*TAGW-1:0] rsp_tag,
    input  logic [NCH*IDW-1:0]  rsp_id,
    input  logic [TAGW-1:0]     cur_tag,
    input  logic [IDW-1:0]      cur_id,
    output logic [NCH-1:0]      hit
);
    logic [NCH-1:0] good;

    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        // Reply qualifies only with matching tag and identifier.
        assign good[c] = rsp_valid[c]
                      && (rsp_tag[c*TAGW +: TAGW] == cur_tag)
                      && (rsp_id[c*IDW +: IDW] == cur_id);
    end

    // Accumulate qualifying replies until the next clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   hit <= '0;
        else if (clr) hit <= '0;
        else if (cap) hit <= hit | good;
    end
endmodule

// File: rtl/evid_match_seq.sv
// Event ID matching sequencer top. Queues trigger identifiers, makes one
// current, issues tagged requests every GAP+1 cycles and retires the
// identifier once every enabled channel has replied with the latest tag
// and the current identifier. A halt bit (set at reset) stops requests;
// a force strobe while halted skips the current identifier.
// Assumes DEPTH <= 15 so the occupancy fits the 4-bit status field.
module evid_match_seq #(
    parameter int NCH     = 4,
    parameter int IDW     = 36,
    parameter int TAGW    = 4,
    parameter int RETRYW  = 16,
    parameter int GAPW    = 16,
    parameter int DEPTH   = 8,
    parameter int GAP_RST = 16'h07FF,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_valid,
    input  logic [IDW-1:0]      trig_id,
    input  logic [NCH-1:0]      chan_en,
    input  logic [NCH-1:0]      rsp_valid,
    input  logic [NCH*TAGW-1:0] rsp_tag,
    input  logic [NCH*IDW-1:0]  rsp_id,
    input  logic [GAPW-1:0]     cfg_wdata,
    input  logic                cfg_halt_we,
    input  logic                cfg_gap_we,
    input  logic                force_stb,
    output logic                req_valid,
    output logic [TAGW-1:0]     cur_tag,
    output logic                halted,
    output logic [IDW-1:0]      cur_id,
    output logic [IDW-1:0]      newest_id,
    output logic [CW-1:0]       fifo_count,
    output logic [RETRYW-1:0]   retry_count
);
    import evid_pkg::*;

    localparam logic [RETRYW-1:0] RETRY_MAX = '1;

    seq_state_t     state;
    logic           halt_q;
    logic [GAPW-1:0] gap_q, gap_cnt;
    logic [IDW-1:0] head;
    logic           q_empty, pop, issue, cap, all_hit;
    logic [NCH-1:0] hit;
    logic           cur_valid;

    assign cur_valid = (state == SEQ_ACTIVE);
    assign halted    = halt_q;
    assign pop       = (state == SEQ_IDLE) && !q_empty;
    assign all_hit   = (&(hit | ~chan_en)) && (retry_count != '0);
    assign issue     = cur_valid && !halt_q && !all_hit && (gap_cnt == '0);
    assign cap       = cur_valid && !halt_q && (gap_cnt != '0);

    evid_fifo #(.W(IDW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (trig_valid),
        .din   (trig_id),
        .pop   (pop),
        .dout  (head),
        .empty (q_empty),
        .count (fifo_count)
    );

    evid_hit_track #(.NCH(NCH), .IDW(IDW), .TAGW(TAGW)) u_hits (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (issue || pop),
        .cap       (cap),
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .rsp_id    (rsp_id),
        .cur_tag   (cur_tag),
        .cur_id    (cur_id),
        .hit       (hit)
    );

    // Control registers: halt bit and re-request interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b1;
            gap_q  <= GAPW'(GAP_RST);
        end else begin
            if (cfg_halt_we) halt_q <= cfg_wdata[0];
            if (cfg_gap_we)  gap_q  <= cfg_wdata;
        end
    end

    // Newest identifier capture, independent of queue space.
    always_ff @(posedge clk) begin
        if (!rst_n)          newest_id <= '0;
        else if (trig_valid) newest_id <= trig_id;
    end

    // Sequencer: load, request, wait, retire or skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            cur_id      <= '0;
            cur_tag     <= '0;
            retry_count <= '0;
            gap_cnt     <= '0;
            req_valid   <= 1'b0;
        end else begin
            req_valid <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (pop) begin
                        cur_id      <= head;
                        retry_count <= '0;
                        gap_cnt     <= '0;
                        state       <= SEQ_ACTIVE;
                    end
                end
                SEQ_ACTIVE: begin
                    if (halt_q) begin
                        gap_cnt <= '0;
                        if (force_stb) state <= SEQ_IDLE;
                    end else if (all_hit) begin
                        state <= SEQ_IDLE;
                    end else if (issue) begin
                        req_valid <= 1'b1;
                        cur_tag   <= cur_tag + 1'b1;
                        gap_cnt   <= gap_q;
                        if (retry_count != RETRY_MAX)
                            retry_count <= retry_count + 1'b1;
                    end else begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/evid_match_seq_chk.sv
// Assertion checker for evid_match_seq, attached by bind below.
// Assumes synchronous inputs and an active-low synchronous reset.
module evid_match_seq_chk #(
    parameter int TAGW   = 4,
    parameter int RETRYW = 16,
    parameter int GAPW   = 16,
    parameter int DEPTH  = 8,
    parameter int CW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [TAGW-1:0]   cur_tag,
    input logic              halted,
    input logic              cur_valid,
    input logic [GAPW-1:0]   gap_q,
    input logic [CW-1:0]     fifo_count,
    input logic [RETRYW-1:0] retry_count
);
    localparam logic [RETRYW-1:0] RMAX = '1;

    a_r3_no_req_halted: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !$past(halted));

    a_r11_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(cur_valid));

    a_r7_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (cur_tag == $past(cur_tag) + TAGW'(1)));

    a_r7_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> $stable(cur_tag));

    a_r6_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ($past(gap_q) != '0)) |=> !req_valid);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    a_r8_retry_step: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_count != $past(retry_count)) |->
            ((retry_count == $past(retry_count) + RETRYW'(1)) || (retry_count == '0)));

    a_r9_retry_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(retry_count) == RMAX) && (retry_count != '0)) |-> (retry_count == RMAX));
endmodule

bind evid_match_seq evid_match_seq_chk #(
    .TAGW(TAGW), .RETRYW(RETRYW), .GAPW(GAPW), .DEPTH(DEPTH), .CW(CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .cur_tag     (cur_tag),
    .halted      (halted),
    .cur_valid   (cur_valid),
    .gap_q       (gap_q),
    .fifo_count  (fifo_count),
    .retry_count (retry_count)
);

// File: tb/evid_match_seq_bench.sv
// Self-checking bench: directed corner cases plus seeded random rounds.
module evid_match_seq_bench;
    localparam int NCH = 4;
    localparam int IDW = 36;
    localparam int NR  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_valid = 1'b0;
    logic [IDW-1:0]    trig_id = '0;
    logic [NCH-1:0]    chan_en = '0;
    logic [NCH-1:0]    rsp_valid = '0;
    logic [NCH*4-1:0]  rsp_tag = '0;
    logic [NCH*IDW-1:0] rsp_id = '0;
    logic [15:0]       cfg_wdata = '0;
    logic              cfg_halt_we = 1'b0;
    logic              cfg_gap_we = 1'b0;
    logic              force_stb = 1'b0;
    logic              req_valid;
    logic [3:0]        cur_tag;
    logic              halted;
    logic [IDW-1:0]    cur_id;
    logic [IDW-1:0]    newest_id;
    logic [3:0]        fifo_count;
    logic [15:0]       retry_count;

    int checks = 0;
    int errors = 0;
    int nreq   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    evid_match_seq u_evid_match_seq (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_id(trig_id),
        .chan_en(chan_en), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_id(rsp_id),
        .cfg_wdata(cfg_wdata), .cfg_halt_we(cfg_halt_we), .cfg_gap_we(cfg_gap_we),
        .force_stb(force_stb), .req_valid(req_valid), .cur_tag(cur_tag),
        .halted(halted), .cur_id(cur_id), .newest_id(newest_id),
        .fifo_count(fifo_count), .retry_count(retry_count)
    );

    // Request monitor on the falling edge.
    always @(negedge clk) if (rst_n && req_valid) nreq++;

    function automatic logic [3:0] exp_tag(input int n);
        return 4'(n % 16);
    endfunction

    function automatic logic [IDW-1:0] rand_id();
        return {4'($urandom()), 32'($urandom())};
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic push(input logic [IDW-1:0] v);
        trig_valid = 1'b1; trig_id = v;
        tick(1);
        trig_valid = 1'b0;
    endtask

    task automatic wr_halt(input bit b);
        cfg_wdata = {15'd0, b}; cfg_halt_we = 1'b1;
        tick(1);
        cfg_halt_we = 1'b0;
    endtask

    task automatic wr_gap(input logic [15:0] g);
        cfg_wdata = g; cfg_gap_we = 1'b1;
        tick(1);
        cfg_gap_we = 1'b0;
    endtask

    task automatic pulse_force();
        force_stb = 1'b1;
        tick(1);
        force_stb = 1'b0;
    endtask

    task automatic reply(input logic [NCH-1:0] mask, input logic [3:0] tg,
                         input logic [IDW-1:0] v, input logic [NCH-1:0] bad_id);
        for (int c = 0; c < NCH; c++) begin
            rsp_tag[c*4 +: 4]    = tg;
            rsp_id[c*IDW +: IDW] = bad_id[c] ? ~v : v;
        end
        rsp_valid = mask;
        tick(1);
        rsp_valid = '0;
    endtask

    task automatic wait_req(input string what);
        int k;
        k = 0;
        do begin
            tick(1);
            k++;
        end while (!req_valid && k < 400);
        chk({what, " request seen"}, 64'(req_valid), 64'd1);
        chk({"R7 tag ", what}, 64'(cur_tag), 64'(exp_tag(nreq)));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [IDW-1:0] a, b, c, s;
        logic [IDW-1:0] r [NR+1];
        logic [IDW-1:0] q [10];
        int gapn, snap;
        void'($urandom(32'd20240611));
        a = rand_id(); b = rand_id(); c = rand_id();

        tick(3);
        rst_n = 1'b1;
        tick(1);
        // Reset state
        chk("R3 halted at reset", 64'(halted), 64'd1);
        chk("R2 count at reset", 64'(fifo_count), 64'd0);
        chk("R7 tag at reset", 64'(cur_tag), 64'd0);
        chk("R8 retry at reset", 64'(retry_count), 64'd0);
        chk("R1 cur_id at reset", 64'(cur_id), 64'd0);

        // Halted: load three, first becomes current
        chan_en = 4'b0011;
        push(a); push(b); push(c);
        tick(3);
        chk("R1 newest", 64'(newest_id), 64'(c));
        chk("R1 current", 64'(cur_id), 64'(a));
        chk("R2 count excludes current", 64'(fifo_count), 64'd2);
        tick(40);
        chk("R3 no requests while halted", 64'(nreq), 64'd0);

        // Forced skip while halted
        pulse_force();
        tick(4);
        chk("R4 forced advance", 64'(cur_id), 64'(b));
        chk("R4 count after skip", 64'(fifo_count), 64'd1);

        // Run with interval 20
        wr_gap(16'd20);
        wr_halt(1'b0);
        wait_req("first");
        chk("R8 retry after first request", 64'(retry_count), 64'd1);
        gapn = 0;
        do begin tick(1); gapn++; end while (!req_valid && gapn < 100);
        chk("R6 request spacing", 64'(gapn), 64'd21);
        chk("R8 retry counts", 64'(retry_count), 64'd2);
        pulse_force();
        tick(4);
        chk("R5 force ignored cur", 64'(cur_id), 64'(b));
        chk("R5 force ignored count", 64'(fifo_count), 64'd1);

        // Matching rules
        wait_req("stale");
        reply(4'b0011, cur_tag - 4'd1, b, 4'b0000);
        tick(4);
        chk("R10 stale tag blocks", 64'(fifo_count), 64'd1);
        wait_req("partial");
        reply(4'b0101, cur_tag, b, 4'b0000);
        tick(4);
        chk("R10 missing channel blocks", 64'(fifo_count), 64'd1);
        wait_req("badid");
        reply(4'b0011, cur_tag, b, 4'b0010);
        tick(4);
        chk("R10 wrong id blocks", 64'(cur_id), 64'(b));
        wait_req("good");
        reply(4'b0011, cur_tag, b, 4'b0000);
        tick(6);
        chk("R10 match advances", 64'(cur_id), 64'(c));
        chk("R2 count after match", 64'(fifo_count), 64'd0);
        chk("R8 retry cleared for new id", 64'(retry_count), 64'd1);

        // Last one, then empty idle
        reply(4'b0011, cur_tag, c, 4'b0000);
        tick(4);
        snap = nreq;
        tick(60);
        chk("R11 no requests when empty", 64'(nreq), 64'(snap));

        // Random rounds
        wr_gap(16'd30);
        for (int k = 0; k <= NR; k++) r[k] = rand_id();
        push(r[0]);
        tick(4);
        for (int k = 0; k < NR; k++) begin
            logic [NCH-1:0] en;
            int kind;
            en = 4'($urandom_range(1, 15));
            chan_en = en;
            push(r[k+1]);
            wait_req("rand");
            chk("R1 rand current", 64'(cur_id), 64'(r[k]));
            kind = $urandom_range(0, 2);
            if (kind == 0)      reply(en, cur_tag + 4'd1, r[k], 4'b0000);
            else if (kind == 1) reply(en, cur_tag, r[k], en);
            else                reply(en & (en - 4'd1), cur_tag, r[k], 4'b0000);
            tick(4);
            chk("R10 rand bad reply holds", 64'(fifo_count), 64'd1);
            wait_req("rand good");
            reply(en | 4'($urandom_range(0, 15)), cur_tag, r[k], 4'b0000);
            tick(6);
            chk("R10 rand advance", 64'(cur_id), 64'(r[k+1]));
        end

        // Full queue drops, forced walk
        wr_halt(1'b1);
        tick(2);
        for (int i = 0; i < 10; i++) begin
            q[i] = rand_id();
            push(q[i]);
        end
        tick(1);
        chk("R12 queue caps at 8", 64'(fifo_count), 64'd8);
        chk("R1 newest after drops", 64'(newest_id), 64'(q[9]));
        for (int i = 0; i < 8; i++) begin
            pulse_force();
            tick(4);
            chk("R4 forced walk", 64'(cur_id), 64'(q[i]));
        end
        pulse_force();
        tick(4);
        chk("R12 dropped entries absent", 64'(cur_id), 64'(q[7]));
        chk("R12 queue empty", 64'(fifo_count), 64'd0);

        // Retry saturation
        s = rand_id();
        push(s);
        tick(4);
        chk("R1 saturation id", 64'(cur_id), 64'(s));
        chan_en = 4'b0001;
        wr_gap(16'd0);
        wr_halt(1'b0);
        tick(65600);
        chk("R9 retry saturates", 64'(retry_count), 64'hFFFF);
        wr_halt(1'b1);
        tick(2);
        snap = nreq;
        tick(20);
        chk("R3 halt stops requests", 64'(nreq), 64'(snap));

        finish_run();
    end
endmodule